// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Sequencer

This block keeps a two-bank synchronous DRAM refreshed. An interval timer, whose length is worked out from the clock period and the required average refresh spacing, adds one owed refresh to a small backlog counter at each expiry. While refreshes are owed, the block asks the upstream arbiter for the command bus. When the backlog reaches its limit it also raises an urgent flag, so that the arbiter closes the open banks. When both banks report idle, the block takes the bus and drives an auto-refresh command on the DRAM command pins. It then holds NOPs for the row-cycle time before it releases the bus. The device advances its own refresh row, so the block drives no address.

A low-power request makes the block issue the self-refresh entry command once both banks are idle. It keeps the clock enable low for as long as the request stays high. When the request falls, it raises the clock enable and holds NOPs for the row-cycle time. Self-refresh retains the data on its own, so the backlog is cleared and the interval timer starts again from zero when the device wakes.

Top module: `drf_sched`

## Requirements
- R1: While reset is held, dram_cke is 1, the command pins deselect (cs_n, ras_n, cas_n, we_n all 1), and bus_own, ref_want and ref_urgent are 0.
- R2: REFI_CYC = ceil(REFI_NS*1000 / CLK_PERIOD_PS). When the banks are always idle, the first auto-refresh is on the pins in cycle REFI_CYC+1 after reset release, and each later one follows REFI_CYC cycles after the one before.
- R3: Auto-refresh is encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1. It appears only when bank_idle was 2'b11 and cke was 1 in the cycle before.
- R4: TRC_CYC = ceil(TRC_NS*1000 / CLK_PERIOD_PS). In each of the TRC_CYC cycles after an auto-refresh the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, cke=1) with bus_own=1. In the cycle after that, bus_own is 0.
- R5: The owed-refresh count grows by one per timer expiry and saturates at MAX_PEND. ref_want is 1 while the count is non-zero, and ref_urgent is 1 while it equals MAX_PEND. Expiries that arrive at saturation are lost.
- R6: A backlog drains back to back, with one auto-refresh every TRC_CYC+2 cycles while the banks stay idle. The first one comes the cycle after bank_idle returns to 2'b11.
- R7: Self-refresh entry is encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=0. It appears in the cycle after lp_req is sampled high with bank_idle=2'b11 in idle. It takes priority over an owed auto-refresh and is never issued while a bank is active.
- R8: While in self-refresh, cke stays 0 with the pins deselected for as long as lp_req stays high. No auto-refresh is issued, and the owed count and interval timer are held at zero.
- R9: When lp_req is sampled low in self-refresh, cke is 1 in the next cycle. NOPs with bus_own=1 follow for TRC_CYC cycles, and then the bus is released. The interval timer restarts, so the next auto-refresh comes REFI_CYC+1 cycles after cke rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_idle | input | 2 | One bit per bank, 1 when the bank is precharged |
| lp_req | input | 1 | Low-power request; high asks for self-refresh |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_cke | output | 1 | Clock enable |
| bus_own | output | 1 | The block is driving the command pins |
| ref_want | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | The owed count has reached its limit |

## Verification
The decision to refresh is registered into the sequencer state, and the pins decode from that state. A command therefore appears one cycle after the edge that sees the owed count and idle banks, and a timer expiry becomes a command two edges later. This gives cycle REFI_CYC+1 for the first refresh, a spacing of TRC_CYC+2 while a backlog drains, and REFI_CYC+1 after cke rises on exit. The scoreboard holds the exact cycle of every expected command, worked out from these sums, and the monitor compares the cycle in which each one shows. Inputs change shortly after a rising edge and outputs are read at the falling edge, so each value is judged in the cycle it belongs to.

// File: rtl/drf_pkg.sv
package drf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AREF,
    ST_TRC,
    ST_SRE,
    ST_SRHOLD,
    ST_SREXIT
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic cke;
  } dram_pins_t;

  localparam dram_pins_t PINS_DESEL  = 5'b11111;
  localparam dram_pins_t PINS_NOP    = 5'b01111;
  localparam dram_pins_t PINS_AREF   = 5'b00011;
  localparam dram_pins_t PINS_SRE    = 5'b00010;
  localparam dram_pins_t PINS_SRHOLD = 5'b11110;

  // Cycles needed to cover a span, rounded up.
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period_ps);
    return ceil_div(ns * 1000, period_ps);
  endfunction

endpackage

// File: rtl/drf_interval.sv
module drf_interval #(
  parameter int unsigned REFI_CYC = 1950,
  parameter int unsigned MAX_PEND = 8,
  localparam int TW = $clog2(REFI_CYC),
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  output logic          tick,
  output logic [PW-1:0] pend_cnt,
  output logic          want,
  output logic          urgent
);

  logic [TW-1:0] tmr;
  logic          at_max;

  assign tick   = !clear && (tmr == TW'(REFI_CYC - 1));
  assign at_max = (pend_cnt == PW'(MAX_PEND));
  assign want   = (pend_cnt != '0);
  assign urgent = at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tmr <= '0;
    else if (clear || tick)  tmr <= '0;
    else                     tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt <= '0;
    end else if (clear) begin
      pend_cnt <= '0;
    end else begin
      unique case ({tick, take})
        2'b10:   if (!at_max) pend_cnt <= pend_cnt + 1'b1;
        2'b01:   pend_cnt <= pend_cnt - 1'b1;
        default: pend_cnt <= pend_cnt;
      endcase
    end
  end

endmodule

// File: rtl/drf_seq.sv
module drf_seq
  import drf_pkg::*;
#(
  parameter int unsigned TRC_CYC = 9,
  localparam int CW = $clog2(TRC_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bank_idle,
  input  logic       lp_req,
  input  logic       want,
  input  logic       cke_now,
  output seq_state_e state,
  output logic       take,
  output logic       sr_active
);

  seq_state_e nxt;
  logic [CW-1:0] win;
  logic          may_issue;
  logic          win_done;

  assign may_issue = (bank_idle == 2'b11) && cke_now;
  assign win_done  = (win == '0);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (may_issue && lp_req)    nxt = ST_SRE;
        else if (may_issue && want) nxt = ST_AREF;
      end
      ST_AREF:   nxt = ST_TRC;
      ST_TRC:    if (win_done) nxt = ST_IDLE;
      ST_SRE:    nxt = lp_req ? ST_SRHOLD : ST_SREXIT;
      ST_SRHOLD: if (!lp_req) nxt = ST_SREXIT;
      ST_SREXIT: if (win_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign take      = (state == ST_IDLE) && (nxt == ST_AREF);
  assign sr_active = (state == ST_SRE) || (state == ST_SRHOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win <= '0;
    else if ((nxt != state) && ((nxt == ST_TRC) || (nxt == ST_SREXIT)))
      win <= CW'(TRC_CYC - 1);
    else if (!win_done)
      win <= win - 1'b1;
  end

endmodule

// File: rtl/drf_cmd_enc.sv
module drf_cmd_enc
  import drf_pkg::*;
(
  input  seq_state_e state,
  output dram_pins_t pins,
  output logic       own
);

  always_comb begin
    unique case (state)
      ST_AREF:   pins = PINS_AREF;
      ST_TRC:    pins = PINS_NOP;
      ST_SRE:    pins = PINS_SRE;
      ST_SRHOLD: pins = PINS_SRHOLD;
      ST_SREXIT: pins = PINS_NOP;
      default:   pins = PINS_DESEL;
    endcase
  end

  assign own = (state != ST_IDLE);

endmodule

// File: rtl/drf_sched.sv
module drf_sched
  import drf_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned REFI_NS       = 15600,
  parameter int unsigned TRC_NS        = 70,
  parameter int unsigned MAX_PEND      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bank_idle,
  input  logic       lp_req,
  output logic       dram_cs_n,
  output logic       dram_ras_n,
  output logic       dram_cas_n,
  output logic       dram_we_n,
  output logic       dram_cke,
  output logic       bus_own,
  output logic       ref_want,
  output logic       ref_urgent
);

  localparam int unsigned REFI_CYC = ns_to_cycles(REFI_NS, CLK_PERIOD_PS);
  localparam int unsigned TRC_CYC  = ns_to_cycles(TRC_NS, CLK_PERIOD_PS);
  localparam int PW = $clog2(MAX_PEND + 1);

  // Named internal events, brought out for the checker.
  logic          tick;
  logic          take;
  logic          sr_active;
  logic [PW-1:0] pend_cnt;
  seq_state_e    state;
  dram_pins_t    pins;

  drf_interval #(.REFI_CYC(REFI_CYC), .MAX_PEND(MAX_PEND)) u_interval (
    .clk(clk), .rst_n(rst_n), .clear(sr_active), .take(take),
    .tick(tick), .pend_cnt(pend_cnt), .want(ref_want), .urgent(ref_urgent)
  );

  drf_seq #(.TRC_CYC(TRC_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .bank_idle(bank_idle), .lp_req(lp_req),
    .want(ref_want), .cke_now(pins.cke), .state(state), .take(take),
    .sr_active(sr_active)
  );

  drf_cmd_enc u_enc (
    .state(state), .pins(pins), .own(bus_own)
  );

  assign dram_cs_n  = pins.cs_n;
  assign dram_ras_n = pins.ras_n;
  assign dram_cas_n = pins.cas_n;
  assign dram_we_n  = pins.we_n;
  assign dram_cke   = pins.cke;

endmodule

// File: rtl/drf_sva.sv
module drf_sva #(
  parameter int unsigned MAX_PEND = 8,
  parameter int unsigned TRC_CYC  = 9,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bank_idle,
  input logic          lp_req,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          cke,
  input logic          bus_own,
  input logic          ref_urgent,
  input logic          tick,
  input logic [PW-1:0] pend_cnt
);

  localparam int CW = $clog2(TRC_CYC + 2);

  logic aref_p, sre_p, nop_p;
  logic [CW-1:0] win;

  assign aref_p = !cs_n && !ras_n && !cas_n && we_n && cke;
  assign sre_p  = !cs_n && !ras_n && !cas_n && we_n && !cke;
  assign nop_p  = !cs_n && ras_n && cas_n && we_n && cke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         win <= '0;
    else if (aref_p)    win <= CW'(TRC_CYC);
    else if (win != '0) win <= win - 1'b1;
  end

  a_r3_aref_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    aref_p |-> ($past(bank_idle) == 2'b11) && $past(cke));

  a_r4_trc_nop_window: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) |-> (nop_p && bus_own));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(MAX_PEND));

  a_r5_urgent_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_urgent) |-> $past(tick));

  a_r7_sre_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sre_p |-> ($past(bank_idle) == 2'b11) && $past(lp_req));

  a_r8_cke_low_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> $past(lp_req));

  a_r9_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (nop_p && bus_own));

endmodule

bind drf_sched drf_sva #(.MAX_PEND(MAX_PEND), .TRC_CYC(TRC_CYC), .PW(PW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bank_idle(bank_idle), .lp_req(lp_req),
  .cs_n(dram_cs_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .cke(dram_cke), .bus_own(bus_own), .ref_urgent(ref_urgent),
  .tick(tick), .pend_cnt(pend_cnt)
);

// File: tb/sim_drf_sched.sv
`timescale 1ns/1ps
module sim_drf_sched;

  localparam int PERIOD_PS = 8000;
  localparam int REFI_NS   = 1600;
  localparam int TRC_NS    = 70;
  localparam int PEND_LIM  = 3;
  // Restated independently: round the span up to whole clocks.
  localparam int B_REFI = (REFI_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int B_TRC  = (TRC_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int B_GAP  = B_TRC + 2;

  localparam int REL_CYC  = 1250;
  localparam int LP_ON    = 1500;
  localparam int LP_OFF   = 1800;
  localparam int END_CYC  = 2300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bank_idle = 2'b11;
  logic lp_req = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, bus_own, ref_want, ref_urgent;

  always #4 clk = ~clk;

  drf_sched #(.CLK_PERIOD_PS(PERIOD_PS), .REFI_NS(REFI_NS), .TRC_NS(TRC_NS),
              .MAX_PEND(PEND_LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .bank_idle(bank_idle), .lp_req(lp_req),
    .dram_cs_n(cs_n), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_cke(cke), .bus_own(bus_own), .ref_want(ref_want), .ref_urgent(ref_urgent)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  typedef struct {
    bit    is_sre;
    int    at;
    string req;
  } exp_item_t;

  exp_item_t sb[$];

  task automatic push_exp(input bit is_sre, input int at, input string req);
    exp_item_t it;
    it.is_sre = is_sre;
    it.at = at;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic wait_cyc(input int n);
    do begin
      @(posedge clk);
      #2;
    end while (cyc < n);
  endtask

  // Monitor: decode commands at the falling edge and score them.
  logic [1:0] prev_idle = 2'b11;
  int win_b = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit is_aref = !cs_n && !ras_n && !cas_n && we_n && cke;
      automatic bit is_sre  = !cs_n && !ras_n && !cas_n && we_n && !cke;
      automatic bit is_nop  = !cs_n && ras_n && cas_n && we_n && cke;
      if (is_aref || is_sre) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "unexpected command", int'(is_sre), -1);
        end else begin
          automatic exp_item_t it = sb.pop_front();
          chk(is_sre == it.is_sre, it.req, "command kind", int'(is_sre), int'(it.is_sre));
          chk(cyc == it.at, it.req, "command cycle", cyc, it.at);
        end
        if (is_aref) chk(prev_idle == 2'b11, "R3", "banks idle before refresh", int'(prev_idle), 3);
        else         chk(prev_idle == 2'b11, "R7", "banks idle before entry", int'(prev_idle), 3);
      end
      if (is_aref) begin
        win_b = 1;
      end else if (win_b > 0) begin
        if (win_b <= B_TRC) begin
          chk(is_nop && bus_own, "R4", "NOP inside row-cycle window", int'(is_nop && bus_own), 1);
          win_b++;
        end else begin
          chk(!bus_own, "R4", "bus released after window", int'(bus_own), 0);
          win_b = 0;
        end
      end
      prev_idle = bank_idle;
    end
  end

  initial begin
    // R1: reset state
    #13;
    chk(cke === 1'b1, "R1", "cke in reset", int'(cke), 1);
    chk({cs_n, ras_n, cas_n, we_n} === 4'b1111, "R1", "deselect in reset",
        int'({cs_n, ras_n, cas_n, we_n}), 15);
    chk({bus_own, ref_want, ref_urgent} === 3'b000, "R1", "flags in reset",
        int'({bus_own, ref_want, ref_urgent}), 0);

    // Scoreboard expectations.
    push_exp(1'b0, B_REFI + 1, "R2");
    push_exp(1'b0, 2 * B_REFI + 1, "R2");
    push_exp(1'b0, REL_CYC + 1, "R6");
    push_exp(1'b0, REL_CYC + 1 + B_GAP, "R6");
    push_exp(1'b0, REL_CYC + 1 + 2 * B_GAP, "R6");
    push_exp(1'b0, 7 * B_REFI + 1, "R5");
    push_exp(1'b1, LP_ON + 1, "R7");
    push_exp(1'b0, LP_OFF + 1 + B_REFI + 1, "R9");
    push_exp(1'b0, LP_OFF + 1 + 2 * B_REFI + 1, "R9");

    @(posedge clk);
    #2 rst_n = 1'b1;

    // Bank busy: backlog builds and saturates (R5).
    wait_cyc(450);
    bank_idle = 2'b01;
    wait_cyc(3 * B_REFI + 100);
    chk(ref_want == 1'b1, "R5", "want with backlog", int'(ref_want), 1);
    chk(ref_urgent == 1'b0, "R5", "urgent below limit", int'(ref_urgent), 0);
    wait_cyc(5 * B_REFI + 50);
    chk(ref_urgent == 1'b1, "R5", "urgent at limit", int'(ref_urgent), 1);
    chk(bus_own == 1'b0, "R3", "no refresh while busy", int'(bus_own), 0);
    wait_cyc(REL_CYC);
    bank_idle = 2'b11;
    wait_cyc(REL_CYC + 2);
    chk(ref_urgent == 1'b0, "R5", "urgent clears after one refresh", int'(ref_urgent), 0);

    // Self-refresh (R7, R8, R9).
    wait_cyc(LP_ON);
    lp_req = 1'b1;
    wait_cyc(LP_ON + 100);
    chk(cke == 1'b0, "R8", "cke held low", int'(cke), 0);
    chk(cs_n == 1'b1, "R8", "pins deselected", int'(cs_n), 1);
    chk(ref_want == 1'b0, "R8", "backlog held clear", int'(ref_want), 0);
    wait_cyc(LP_OFF);
    lp_req = 1'b0;
    wait_cyc(LP_OFF + 1);
    chk(cke == 1'b1, "R9", "cke rises after request drops", int'(cke), 1);
    wait_cyc(LP_OFF + 5);
    chk(bus_own == 1'b1 && cs_n == 1'b0 && ras_n == 1'b1, "R9", "NOP hold after exit",
        int'(bus_own), 1);
    wait_cyc(LP_OFF + 1 + B_TRC);
    chk(bus_own == 1'b0, "R9", "bus released after exit window", int'(bus_own), 0);

    // Low-power request while a bank is active: no entry (R7).
    wait_cyc(2100);
    bank_idle = 2'b10;
    lp_req = 1'b1;
    wait_cyc(2140);
    chk(cke == 1'b1 && bus_own == 1'b0, "R7", "no entry while bank active",
        int'(cke && !bus_own), 1);
    wait_cyc(2150);
    lp_req = 1'b0;
    bank_idle = 2'b11;

    wait_cyc(END_CYC);
    chk(sb.size() == 0, "R2", "all expected commands seen", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", cyc, END_CYC);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule